// File: doc/BRIEF.md
# Operand Forwarding and Load-Use Interlock

This block handles hazards for a five-stage in-order integer pipeline. Registers are read in the decode stage and written in the final stage. Instructions never change order, so the only conflict is a read that comes before a write that has not yet landed. For each of the two source operands of the instruction in the execute stage, the block picks where the ALU input comes from: the register-file read, the result held in the memory-stage pipeline register, or the result held in the write-back pipeline register.

A result from a load is only ready at the end of the memory stage. An instruction that reads that register and sits directly behind the load therefore cannot be served by forwarding. The block detects this pair while the consumer is in decode and the load is in execute. For one cycle it freezes the fetch address and the fetch/decode register and puts an empty slot into execute. The later stages keep moving, so the load still completes. The block includes a small shell of pipeline registers that carries only instruction tags (valid, write flag, load flag, destination and source register numbers), so the control can be driven on its own.

Top module: `fwd_interlock`

## Requirements
- R1: After the asynchronous active-low reset, all stage tags are empty, both operand selects read 2'b00, and hold and bubble are low.
- R2: An operand whose register number equals the destination of a valid, writing instruction one stage ahead (in the memory stage) gets select 2'b10.
- R3: An operand whose register number equals the destination of a valid, writing instruction two stages ahead (in write-back), with no match one stage ahead, gets select 2'b01.
- R4: When both the memory-stage and the write-back-stage producers match the same operand, the memory-stage source (2'b10) wins.
- R5: Register number 0 never causes forwarding (select 2'b00) and never causes a stall, even when a producer writes register 0.
- R6: A tag with its write flag low, or with valid low, is never a forwarding source.
- R7: A valid load with a nonzero destination in execute, followed in decode by a valid instruction that reads that register on either operand, raises hold and bubble for exactly one cycle. The consumer reaches execute one cycle late and takes the load value through select 2'b01.
- R8: A consumer two or more slots behind a load is not stalled, and takes the value through forwarding if the load is still in flight.
- R9: During a stall, the fetch/decode tag stays unchanged, execute receives an empty slot, and the tags in execute and memory advance one stage.
- R10: Hold and bubble are always equal, and are never high for two cycles in a row.
- R11: Select 2'b10 is never chosen while the memory-stage tag is a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Incoming instruction slot is valid |
| in_we_i | input | 1 | Incoming instruction writes its destination |
| in_load_i | input | 1 | Incoming instruction is a load |
| in_rd_i | input | 5 | Incoming destination register |
| in_rs1_i | input | 5 | Incoming first source register |
| in_rs2_i | input | 5 | Incoming second source register |
| fwd_a_o | output | 2 | First ALU operand select: 00 register file, 10 memory stage, 01 write-back |
| fwd_b_o | output | 2 | Second ALU operand select, same encoding |
| hold_o | output | 1 | Freeze fetch address and fetch/decode register |
| bubble_o | output | 1 | Load an empty slot into the decode/execute register |
| ex_valid_o | output | 1 | Execute stage holds a valid instruction |
| ex_rd_o | output | 5 | Destination register of the instruction in execute |

## Verification
The assertions assume that the input tag is only taken when hold is low. They also assume that the surrounding pipeline never moves an instruction the block has frozen. The shell itself enforces both. Beyond that, the assertions assume no particular instruction mix. The stimulus is issued only through a driver that keeps the input steady until it is accepted, and it uses back-to-back dependences, producers to register 0, non-writing and invalid producers, and chained loads. A scoreboard model tracks the execute slot of every instruction. From those slots it derives each expected select and each expected stall gap.

// File: rtl/fwd_interlock_pkg.sv
package fwd_interlock_pkg;
  localparam int unsigned REG_AW = 5;

  typedef enum logic [1:0] {
    SRC_RF  = 2'b00,
    SRC_WB  = 2'b01,
    SRC_MEM = 2'b10
  } src_sel_e;

  typedef struct packed {
    logic              valid;
    logic              we;
    logic              load;
    logic [REG_AW-1:0] rd;
    logic [REG_AW-1:0] rs1;
    logic [REG_AW-1:0] rs2;
  } stage_tag_t;
endpackage

// File: rtl/fwd_sel.sv
module fwd_sel
  import fwd_interlock_pkg::*;
(
  input  logic [REG_AW-1:0] src_i,
  input  logic              use_i,
  input  stage_tag_t        mem_i,
  input  stage_tag_t        wb_i,
  output src_sel_e          sel_o
);
  logic hit_mem, hit_wb, src_nz;

  assign src_nz  = |src_i;
  assign hit_mem = use_i && src_nz && mem_i.valid && mem_i.we && (mem_i.rd == src_i);
  assign hit_wb  = use_i && src_nz && wb_i.valid  && wb_i.we  && (wb_i.rd  == src_i);

  // nearer producer holds the newest value
  always_comb begin
    if (hit_mem)     sel_o = SRC_MEM;
    else if (hit_wb) sel_o = SRC_WB;
    else             sel_o = SRC_RF;
  end
endmodule

// File: rtl/load_interlock.sv
module load_interlock
  import fwd_interlock_pkg::*;
(
  input  stage_tag_t id_i,
  input  stage_tag_t ex_i,
  output logic       stall_o
);
  logic ld_live, hit1, hit2;

  assign ld_live = ex_i.valid && ex_i.load && ex_i.we && (|ex_i.rd);
  assign hit1    = (id_i.rs1 == ex_i.rd);
  assign hit2    = (id_i.rs2 == ex_i.rd);
  assign stall_o = ld_live && id_i.valid && (hit1 || hit2);
endmodule

// File: rtl/tag_pipe.sv
module tag_pipe
  import fwd_interlock_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  stage_tag_t in_i,
  input  logic       stall_i,
  output stage_tag_t id_o,
  output stage_tag_t ex_o,
  output stage_tag_t mem_o,
  output stage_tag_t wb_o
);
  stage_tag_t id_q, ex_q, mem_q, wb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      id_q  <= '0;
      ex_q  <= '0;
      mem_q <= '0;
      wb_q  <= '0;
    end else begin
      if (!stall_i) id_q <= in_i;
      ex_q  <= stall_i ? '0 : id_q;
      mem_q <= ex_q;
      wb_q  <= mem_q;
    end
  end

  assign id_o  = id_q;
  assign ex_o  = ex_q;
  assign mem_o = mem_q;
  assign wb_o  = wb_q;
endmodule

// File: rtl/fwd_interlock.sv
module fwd_interlock
  import fwd_interlock_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic              in_we_i,
  input  logic              in_load_i,
  input  logic [REG_AW-1:0] in_rd_i,
  input  logic [REG_AW-1:0] in_rs1_i,
  input  logic [REG_AW-1:0] in_rs2_i,
  output logic [1:0]        fwd_a_o,
  output logic [1:0]        fwd_b_o,
  output logic              hold_o,
  output logic              bubble_o,
  output logic              ex_valid_o,
  output logic [REG_AW-1:0] ex_rd_o
);
  localparam int unsigned N_OPS = 2;

  stage_tag_t in_tag, id_t, ex_t, mem_t, wb_t;
  logic       stall;
  logic [REG_AW-1:0] src [N_OPS];
  src_sel_e          sel [N_OPS];

  assign in_tag = '{valid: in_valid_i, we: in_we_i, load: in_load_i,
                    rd: in_rd_i, rs1: in_rs1_i, rs2: in_rs2_i};

  tag_pipe u_pipe (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .in_i    (in_tag),
    .stall_i (stall),
    .id_o    (id_t),
    .ex_o    (ex_t),
    .mem_o   (mem_t),
    .wb_o    (wb_t)
  );

  load_interlock u_ldi (
    .id_i    (id_t),
    .ex_i    (ex_t),
    .stall_o (stall)
  );

  assign src[0] = ex_t.rs1;
  assign src[1] = ex_t.rs2;

  for (genvar g = 0; g < N_OPS; g++) begin : g_op
    fwd_sel u_sel (
      .src_i (src[g]),
      .use_i (ex_t.valid),
      .mem_i (mem_t),
      .wb_i  (wb_t),
      .sel_o (sel[g])
    );
  end

  assign fwd_a_o    = sel[0];
  assign fwd_b_o    = sel[1];
  assign hold_o     = stall;
  assign bubble_o   = stall;
  assign ex_valid_o = ex_t.valid;
  assign ex_rd_o    = ex_t.rd;
endmodule

// File: rtl/fwd_interlock_chk.sv
module fwd_interlock_chk
  import fwd_interlock_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] fwd_a_o,
  input logic [1:0] fwd_b_o,
  input logic       hold_o,
  input logic       bubble_o,
  input stage_tag_t id_t,
  input stage_tag_t ex_t,
  input stage_tag_t mem_t
);
  p_mem_src_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_a_o == SRC_MEM |-> mem_t.valid && mem_t.we && mem_t.rd == ex_t.rs1);

  p_sel_legal_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(fwd_a_o) && $onehot0(fwd_b_o));

  p_zero_reg_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ex_t.rs1 == '0 |-> fwd_a_o == SRC_RF);

  p_stall_flow_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_o |=> id_t == $past(id_t) && !ex_t.valid && mem_t == $past(ex_t));

  p_single_stall_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_o |=> !hold_o);

  p_hold_bubble_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_o == bubble_o);

  p_no_load_mem_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_t.valid && mem_t.load) |-> fwd_a_o != SRC_MEM && fwd_b_o != SRC_MEM);
endmodule

bind fwd_interlock fwd_interlock_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .fwd_a_o  (fwd_a_o),
  .fwd_b_o  (fwd_b_o),
  .hold_o   (hold_o),
  .bubble_o (bubble_o),
  .id_t     (id_t),
  .ex_t     (ex_t),
  .mem_t    (mem_t)
);

// File: tb/fwd_interlock_tb.sv
module fwd_interlock_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_we = 1'b0, in_load = 1'b0;
  logic [4:0] in_rd = '0, in_rs1 = '0, in_rs2 = '0;
  logic [1:0] fwd_a, fwd_b;
  logic hold, bubble, ex_valid;
  logic [4:0] ex_rd;

  int n_tests = 0, n_fail = 0;

  always #2 clk = ~clk;

  fwd_interlock u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_we_i(in_we), .in_load_i(in_load),
    .in_rd_i(in_rd), .in_rs1_i(in_rs1), .in_rs2_i(in_rs2),
    .fwd_a_o(fwd_a), .fwd_b_o(fwd_b), .hold_o(hold), .bubble_o(bubble),
    .ex_valid_o(ex_valid), .ex_rd_o(ex_rd)
  );

  typedef struct {
    logic [4:0] rd;
    logic [1:0] fa;
    logic [1:0] fb;
    int         gap;
    string      req;
  } exp_t;

  typedef struct {
    logic       v;
    logic       we;
    logic       ld;
    logic [4:0] rd;
  } slot_t;

  exp_t  sb_q[$];
  slot_t slots[0:255];
  int    cur_e = 0, last_valid_e = -1, exp_stalls = 0, seen_stalls = 0;
  bit    done = 0;

  function automatic logic [1:0] exp_sel(int e, logic [4:0] s);
    if (s == 0) return 2'b00;
    if (e >= 1 && slots[e-1].v && slots[e-1].we && slots[e-1].rd == s) return 2'b10;
    if (e >= 2 && slots[e-2].v && slots[e-2].we && slots[e-2].rd == s) return 2'b01;
    return 2'b00;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // driver: model the execute slot of each instruction, push expectation, then issue
  task automatic issue(logic v, logic we, logic ld, logic [4:0] rd,
                       logic [4:0] rs1, logic [4:0] rs2, string req);
    slot_t p;
    int    st, e;
    exp_t  x;
    p  = slots[cur_e];
    st = (v && p.v && p.ld && p.we && p.rd != 0 && (p.rd == rs1 || p.rd == rs2)) ? 1 : 0;
    e  = cur_e + 1 + st;
    if (st == 1) begin
      slots[cur_e+1] = '{v: 1'b0, we: 1'b0, ld: 1'b0, rd: 5'd0};
      exp_stalls++;
    end
    slots[e] = '{v: v, we: we, ld: ld, rd: rd};
    if (v) begin
      x.rd  = rd;
      x.fa  = exp_sel(e, rs1);
      x.fb  = exp_sel(e, rs2);
      x.gap = (last_valid_e < 0) ? -1 : e - last_valid_e - 1;
      x.req = req;
      sb_q.push_back(x);
      last_valid_e = e;
    end
    cur_e = e;
    in_valid = v; in_we = we; in_load = ld;
    in_rd = rd; in_rs1 = rs1; in_rs2 = rs2;
    forever begin
      if (!hold) begin
        @(negedge clk);
        break;
      end
      @(negedge clk);
    end
  endtask

  // monitor: compare each valid execute slot with the next expectation
  initial begin : monitor
    int   idle = 0;
    bit   first = 1;
    exp_t x;
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      if (hold) seen_stalls++;
      if (ex_valid) begin
        if (sb_q.size() == 0) begin
          check(0, "R9", "unexpected instruction in execute", ex_rd, 0);
        end else begin
          x = sb_q.pop_front();
          check(ex_rd == x.rd, x.req, "execute order rd", ex_rd, x.rd);
          check(fwd_a == x.fa, x.req, "operand A select", fwd_a, x.fa);
          check(fwd_b == x.fb, x.req, "operand B select", fwd_b, x.fb);
          if (!first && x.gap >= 0)
            check(idle == x.gap, x.req, "empty slots before instruction", idle, x.gap);
        end
        first = 0;
        idle  = 0;
      end else if (!first) begin
        idle++;
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : stim
    for (int i = 0; i < 256; i++) slots[i] = '{v: 1'b0, we: 1'b0, ld: 1'b0, rd: 5'd0};
    repeat (3) @(negedge clk);
    // R1: reset values
    check(fwd_a == 2'b00 && fwd_b == 2'b00, "R1", "selects in reset", {fwd_a, fwd_b}, 0);
    check(!hold && !bubble && !ex_valid, "R1", "hold/bubble/valid in reset",
          {hold, bubble, ex_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(fwd_a == 2'b00 && !hold && !ex_valid, "R1", "state after release",
          {fwd_a, hold, ex_valid}, 0);

    // R2: back-to-back ALU dependence
    issue(1, 1, 0, 5'd1, 5'd4, 5'd6, "R2");
    issue(1, 1, 0, 5'd2, 5'd1, 5'd6, "R2");
    issue(1, 1, 0, 5'd3, 5'd7, 5'd2, "R2");
    // R3: dependence two slots apart
    issue(1, 1, 0, 5'd8, 5'd0, 5'd0, "R3");
    issue(1, 0, 0, 5'd20, 5'd0, 5'd0, "R3");
    issue(1, 1, 0, 5'd21, 5'd0, 5'd8, "R3");
    // R4: both producers write the same register
    issue(1, 1, 0, 5'd5, 5'd0, 5'd0, "R4");
    issue(1, 1, 0, 5'd5, 5'd0, 5'd0, "R4");
    issue(1, 1, 0, 5'd22, 5'd5, 5'd5, "R4");
    // R5: register 0 never forwards or stalls
    issue(1, 1, 0, 5'd0, 5'd1, 5'd1, "R5");
    issue(1, 1, 0, 5'd23, 5'd0, 5'd0, "R5");
    issue(1, 1, 1, 5'd0, 5'd1, 5'd1, "R5");
    issue(1, 1, 0, 5'd24, 5'd0, 5'd0, "R5");
    // R6: non-writing and invalid producers are ignored
    issue(1, 0, 0, 5'd7, 5'd0, 5'd0, "R6");
    issue(1, 1, 0, 5'd25, 5'd7, 5'd0, "R6");
    issue(0, 1, 0, 5'd9, 5'd0, 5'd0, "R6");
    issue(1, 1, 0, 5'd26, 5'd9, 5'd9, "R6");
    // R7: load then immediate consumer on operand B
    issue(1, 1, 1, 5'd10, 5'd1, 5'd0, "R7");
    issue(1, 1, 0, 5'd27, 5'd3, 5'd10, "R7");
    // R7/R9: load, consumer on operand A, then a later reader of the load
    issue(1, 1, 1, 5'd11, 5'd0, 5'd0, "R9");
    issue(1, 1, 0, 5'd28, 5'd11, 5'd0, "R9");
    issue(1, 1, 0, 5'd29, 5'd11, 5'd28, "R9");
    // R8: one independent instruction between load and consumer
    issue(1, 1, 1, 5'd12, 5'd0, 5'd0, "R8");
    issue(1, 1, 0, 5'd30, 5'd0, 5'd0, "R8");
    issue(1, 1, 0, 5'd31, 5'd12, 5'd0, "R8");
    // R10/R11: chained loads, each stalling once
    issue(1, 1, 1, 5'd13, 5'd0, 5'd0, "R10");
    issue(1, 1, 1, 5'd14, 5'd13, 5'd0, "R10");
    issue(1, 1, 0, 5'd15, 5'd0, 5'd14, "R10");
    issue(1, 1, 0, 5'd16, 5'd15, 5'd14, "R11");
    // drain
    for (int i = 0; i < 6; i++) issue(0, 0, 0, 5'd0, 5'd0, 5'd0, "R9");
    check(sb_q.size() == 0, "R9", "instructions left undelivered", sb_q.size(), 0);
    check(seen_stalls == exp_stalls, "R7", "stall cycles", seen_stalls, exp_stalls);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule